// File: doc/BRIEF.md
# Single-Wire Bus Master Core

This block drives a single-wire open-drain bus on behalf of a processor. The processor sees a small byte-wide register window: a command register, a data register, an interrupt status register, an interrupt enable register and a clock divisor register. Writing the command register can launch a bus reset with presence detection. Writing the data register launches eight bit slots that transmit that byte and, at the same time, capture what the bus carried. Writing 0xFF therefore performs a pure read, because a one bit releases the line early and lets a device pull it low.

Completion is reported through sticky status flags and one interrupt line whose polarity is programmable. Reading the status register or the data register acknowledges work, so a handler learns what happened and clears it in the same access. Slot timing runs on a tick of divisor+1 system clocks, and all slot lengths are parameters counted in ticks.

Top module: `owm_master`

## Requirements
- R1: After reset, status (offset 2) reads 0x0C (bits 2 and 3 set), enable (offset 3) and divisor (offset 4) read 0, the interrupt output is inactive (high, because enable bit 1 is 0), and offsets 5 to 7 read 0.
- R2: Writing the command register (offset 0) with bit 0 set while idle drives the bus low for 480 ticks. Command bit 0 reads 1 while the reset sequence runs.
- R3: When the reset sequence ends (480 ticks after the release), status bit 0 is set. Status bit 1 is set to 1 if the line was high 70 ticks after the release and to 0 if a device held it low.
- R4: A write to the data register (offset 1) while idle sends 8 slots of 70 ticks, least significant bit first. A one bit pulls the line low for 6 ticks and a zero bit for 60 ticks. The line is sampled 15 ticks into each slot. The sampled bits, least significant first, form the byte that reads back at offset 1.
- R5: Status bits 2 (transmit empty) and 3 (shift empty) are cleared when a byte starts. Both are set in the cycle the last slot finishes.
- R6: The interrupt is active when any status bit 0, 2, 3, 4 or 5 is set together with the same enable bit. Enable bit 1 = 1 makes the output active high, 0 makes it active low.
- R7: Reading the status register clears status bits 0 and 5 and holds the interrupt inactive until the next completion. A completion that lands in the same cycle as the read keeps its flags set.
- R8: Reading the data register clears status bit 4 and leaves bit 5 unchanged.
- R9: Command bit 3 reads the live level of the bus.
- R10: Writing the command register with bit 5 set aborts any sequence, releases the bus in the next cycle and returns the status to 0x0C. The enable and divisor registers keep their values.
- R11: A data write or a reset command issued while a sequence runs is ignored. The running byte completes with its own data, and no further slots follow.
- R12: One tick lasts divisor+1 clocks. With divisor 3, the reset low phase lasts 1920 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ASHIFT+3 | Register address; the index is taken from bits ASHIFT and up |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; triggers read side effects |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| dq_oe_o | output | 1 | Pull the bus low when 1 |
| dq_i | input | 1 | Sensed bus level |
| irq_o | output | 1 | Interrupt, polarity set by enable bit 1 |

## Verification
Two functions can meet in one cycle: the end of a byte, which raises the completion flags, and a status read, which clears them. The bench counts clocks from the data write to the exact cycle the final slot ends and places the status read in that cycle. That read must return the flags before the completion, and a second read must show the shift-empty and receive flags set, because a new event wins over the clear. The same event also releases the interrupt hold that the read would set.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam logic [2:0] IDX_CMD  = 3'd0;
    localparam logic [2:0] IDX_DATA = 3'd1;
    localparam logic [2:0] IDX_STAT = 3'd2;
    localparam logic [2:0] IDX_ENA  = 3'd3;
    localparam logic [2:0] IDX_DIV  = 3'd4;

    // status bit positions
    localparam int ST_PD   = 0;
    localparam int ST_PDR  = 1;
    localparam int ST_TBE  = 2;
    localparam int ST_TSRE = 3;
    localparam int ST_RBF  = 4;
    localparam int ST_RSRF = 5;

    localparam logic [5:0] IRQ_SRC_MASK = 6'b111101;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RLOW = 2'd1,
        SEQ_RREC = 2'd2,
        SEQ_SLOT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q >= div_i);
        cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/owm_seq.sv
module owm_seq
    import owm_pkg::*;
#(
    parameter int RST_LOW   = 480,
    parameter int PD_SAMPLE = 70,
    parameter int RST_REC   = 480,
    parameter int SLOT_LEN  = 70,
    parameter int LOW0      = 60,
    parameter int LOW1      = 6,
    parameter int SAMPLE    = 15
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       abort_i,
    input  logic       start_rst_i,
    input  logic       start_byte_i,
    input  logic [7:0] tx_i,
    input  logic       dq_i,
    output logic       dq_oe_o,
    output logic       busy_o,
    output logic       in_rst_o,
    output logic       rst_done_o,
    output logic       present_o,
    output logic       byte_done_o,
    output logic [7:0] rx_o
);

    localparam int TMAX_A = (RST_LOW > RST_REC) ? RST_LOW : RST_REC;
    localparam int TMAX   = (TMAX_A > SLOT_LEN) ? TMAX_A : SLOT_LEN;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_RL = TW'(RST_LOW - 1);
    localparam logic [TW-1:0] T_RR = TW'(RST_REC - 1);
    localparam logic [TW-1:0] T_PD = TW'(PD_SAMPLE - 1);
    localparam logic [TW-1:0] T_SL = TW'(SLOT_LEN - 1);
    localparam logic [TW-1:0] T_SM = TW'(SAMPLE - 1);
    localparam logic [TW-1:0] T_L0 = TW'(LOW0);
    localparam logic [TW-1:0] T_L1 = TW'(LOW1);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] t;
        logic [2:0]    idx;
        logic [7:0]    sh;
        logic          rbit;
        logic          pres;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        rst_done_o  = 1'b0;
        byte_done_o = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start_rst_i) begin
                    s_d.st = SEQ_RLOW;
                    s_d.t  = '0;
                end else if (start_byte_i) begin
                    s_d.st  = SEQ_SLOT;
                    s_d.t   = '0;
                    s_d.idx = '0;
                    s_d.sh  = tx_i;
                end
            end
            SEQ_RLOW: begin
                if (tick_i) begin
                    if (s_q.t == T_RL) begin
                        s_d.st = SEQ_RREC;
                        s_d.t  = '0;
                    end else begin
                        s_d.t = s_q.t + 1'b1;
                    end
                end
            end
            SEQ_RREC: begin
                if (tick_i) begin
                    if (s_q.t == T_PD) s_d.pres = !dq_i;
                    if (s_q.t == T_RR) begin
                        s_d.st     = SEQ_IDLE;
                        s_d.t      = '0;
                        rst_done_o = 1'b1;
                    end else begin
                        s_d.t = s_q.t + 1'b1;
                    end
                end
            end
            SEQ_SLOT: begin
                if (tick_i) begin
                    if (s_q.t == T_SM) s_d.rbit = dq_i;
                    if (s_q.t == T_SL) begin
                        s_d.t   = '0;
                        s_d.sh  = {s_q.rbit, s_q.sh[7:1]};
                        s_d.idx = s_q.idx + 1'b1;
                        if (s_q.idx == 3'd7) begin
                            s_d.st      = SEQ_IDLE;
                            byte_done_o = 1'b1;
                        end
                    end else begin
                        s_d.t = s_q.t + 1'b1;
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
        if (abort_i) begin
            s_d         = '0;
            rst_done_o  = 1'b0;
            byte_done_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign dq_oe_o   = (s_q.st == SEQ_RLOW) ||
                       ((s_q.st == SEQ_SLOT) && (s_q.t < (s_q.sh[0] ? T_L1 : T_L0)));
    assign busy_o    = (s_q.st != SEQ_IDLE);
    assign in_rst_o  = (s_q.st == SEQ_RLOW) || (s_q.st == SEQ_RREC);
    assign present_o = s_q.pres;
    assign rx_o      = {s_q.rbit, s_q.sh[7:1]};

endmodule

// File: rtl/owm_master.sv
module owm_master
    import owm_pkg::*;
#(
    parameter int ASHIFT    = 0,
    parameter int DIV_W     = 8,
    parameter int RST_LOW   = 480,
    parameter int PD_SAMPLE = 70,
    parameter int RST_REC   = 480,
    parameter int SLOT_LEN  = 70,
    parameter int LOW0      = 60,
    parameter int LOW1      = 6,
    parameter int SAMPLE    = 15,
    localparam int ADDR_W   = ASHIFT + 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              dq_oe_o,
    input  logic              dq_i,
    output logic              irq_o
);

    typedef struct packed {
        logic [5:0]       en;
        logic [DIV_W-1:0] div;
        logic             pd;
        logic             pdr;
        logic             tbe;
        logic             tsre;
        logic             rbf;
        logic             rsrf;
        logic             hold;
        logic [7:0]       rxb;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0] idx;
    logic       wr_cmd, wr_data, wr_ena, wr_div, rd_stat, rd_data;
    logic       soft_rst, start_rst, start_byte;
    logic       tick, seq_busy, seq_in_rst, rst_done, byte_done, present;
    logic [7:0] rx_byte, status_byte;
    logic       irq_act;

    assign idx        = bus_addr_i[ASHIFT +: 3];
    assign wr_cmd     = bus_wr_i && (idx == IDX_CMD);
    assign wr_data    = bus_wr_i && (idx == IDX_DATA);
    assign wr_ena     = bus_wr_i && (idx == IDX_ENA);
    assign wr_div     = bus_wr_i && (idx == IDX_DIV);
    assign rd_stat    = bus_rd_i && (idx == IDX_STAT);
    assign rd_data    = bus_rd_i && (idx == IDX_DATA);
    assign soft_rst   = wr_cmd && bus_wdata_i[5];
    assign start_rst  = wr_cmd && bus_wdata_i[0] && !soft_rst && !seq_busy;
    assign start_byte = wr_data && !seq_busy;

    owm_tick #(.DIV_W(DIV_W)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (seq_busy),
        .div_i  (r_q.div),
        .tick_o (tick)
    );

    owm_seq #(
        .RST_LOW   (RST_LOW),
        .PD_SAMPLE (PD_SAMPLE),
        .RST_REC   (RST_REC),
        .SLOT_LEN  (SLOT_LEN),
        .LOW0      (LOW0),
        .LOW1      (LOW1),
        .SAMPLE    (SAMPLE)
    ) i_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .abort_i      (soft_rst),
        .start_rst_i  (start_rst),
        .start_byte_i (start_byte),
        .tx_i         (bus_wdata_i),
        .dq_i         (dq_i),
        .dq_oe_o      (dq_oe_o),
        .busy_o       (seq_busy),
        .in_rst_o     (seq_in_rst),
        .rst_done_o   (rst_done),
        .present_o    (present),
        .byte_done_o  (byte_done),
        .rx_o         (rx_byte)
    );

    always_comb begin
        r_d = r_q;
        // acknowledges by read
        if (rd_stat) begin
            r_d.pd   = 1'b0;
            r_d.rsrf = 1'b0;
            r_d.hold = 1'b1;
        end
        if (rd_data) r_d.rbf = 1'b0;
        // sequence launches
        if (start_rst) r_d.tbe = 1'b0;
        if (start_byte) begin
            r_d.tbe  = 1'b0;
            r_d.tsre = 1'b0;
        end
        // completions win over read clears
        if (rst_done) begin
            r_d.pd   = 1'b1;
            r_d.pdr  = !present;
            r_d.tbe  = 1'b1;
            r_d.hold = 1'b0;
        end
        if (byte_done) begin
            r_d.rxb  = rx_byte;
            r_d.rbf  = 1'b1;
            r_d.rsrf = 1'b1;
            r_d.tbe  = 1'b1;
            r_d.tsre = 1'b1;
            r_d.hold = 1'b0;
        end
        if (wr_ena) r_d.en  = bus_wdata_i[5:0];
        if (wr_div) r_d.div = bus_wdata_i[DIV_W-1:0];
        if (soft_rst) begin
            r_d.pd   = 1'b0;
            r_d.pdr  = 1'b0;
            r_d.tbe  = 1'b1;
            r_d.tsre = 1'b1;
            r_d.rbf  = 1'b0;
            r_d.rsrf = 1'b0;
            r_d.hold = 1'b0;
            r_d.rxb  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q      <= '0;
            r_q.tbe  <= 1'b1;
            r_q.tsre <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        status_byte = {2'b00, r_q.rsrf, r_q.rbf, r_q.tsre, r_q.tbe, r_q.pdr, r_q.pd};
        irq_act     = (|(status_byte[5:0] & r_q.en & IRQ_SRC_MASK)) && !r_q.hold;
        irq_o       = r_q.en[1] ? irq_act : !irq_act;
        unique case (idx)
            IDX_CMD:  bus_rdata_o = {4'b0000, dq_i, 2'b00, seq_in_rst};
            IDX_DATA: bus_rdata_o = r_q.rxb;
            IDX_STAT: bus_rdata_o = status_byte;
            IDX_ENA:  bus_rdata_o = {2'b00, r_q.en};
            IDX_DIV:  bus_rdata_o = 8'(r_q.div);
            default:  bus_rdata_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       rd_stat_i,
    input logic       rd_data_i,
    input logic       soft_i,
    input logic       dq_oe_i,
    input logic       busy_i,
    input logic       in_rst_i,
    input logic [7:0] status_i,
    input logic [5:0] en_i,
    input logic       irq_i,
    input logic       rst_done_i,
    input logic       byte_done_i
);

    a_r5_shift_empty_low_in_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !in_rst_i) |-> !status_i[3]);

    a_r2_bus_driven_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dq_oe_i |-> !status_i[2]);

    a_r3_pd_follows_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_i[0]) |-> $past(rst_done_i));

    a_r7_status_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stat_i && !rst_done_i && !byte_done_i) |=> (!status_i[0] && !status_i[5]));

    a_r8_data_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_i && !byte_done_i) |=> !status_i[4]);

    a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_i |=> (!dq_oe_i && status_i == 8'h0C));

    a_r6_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((en_i & 6'b111101) == 6'd0) |-> (irq_i == !en_i[1]));

endmodule

bind owm_master owm_master_chk i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_stat_i   (rd_stat),
    .rd_data_i   (rd_data),
    .soft_i      (soft_rst),
    .dq_oe_i     (dq_oe_o),
    .busy_i      (seq_busy),
    .in_rst_i    (seq_in_rst),
    .status_i    (status_byte),
    .en_i        (r_q.en),
    .irq_i       (irq_o),
    .rst_done_i  (rst_done),
    .byte_done_i (byte_done)
);

// File: tb/test_owm_master.sv
module test_owm_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       dq_oe;
    logic       dq;
    logic       irq;
    logic       slv_pull = 1'b0;
    logic       slv_pres = 1'b0;
    logic [7:0] slv_byte = 8'hFF;
    logic       mon_on = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] expq[$];

    always #5 clk = ~clk;

    assign dq = ~(dq_oe | slv_pull);

    owm_master i_owm_master (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .dq_oe_o     (dq_oe),
        .dq_i        (dq),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic low_len(output int n);
        while (!dq_oe) @(negedge clk);
        n = 0;
        while (dq_oe) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic bus_reset();
        reg_wr(3'd0, 8'h01);
        repeat (1000) @(negedge clk);
    endtask

    // scoreboard driver: push the expected byte, launch the transfer
    task automatic sb_byte(input logic [7:0] tx, input logic [7:0] sv);
        slv_byte = sv;
        expq.push_back(tx & sv);
        reg_wr(3'd1, tx);
        wait (expq.size() == 0);
    endtask

    // device model on the bus
    initial begin
        int  run = 0;
        int  pull = 0;
        int  pw = 0;
        int  bidx = 0;
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (dq_oe) begin
                if (!prev) begin
                    if (slv_byte[bidx] == 1'b0) pull = 30;
                    bidx = (bidx + 1) % 8;
                end
                run++;
            end else begin
                if (prev && run > 200) begin
                    bidx = 0;
                    if (slv_pres) pw = 20;
                end
                run = 0;
            end
            prev = dq_oe;
            if (pw > 0) begin
                pw--;
                if (pw == 0) pull = 120;
            end else if (pull > 0) begin
                pull--;
            end
            slv_pull = (pull > 0);
        end
    end

    // scoreboard monitor: on interrupt, fetch the byte and compare
    initial begin
        logic [7:0] v;
        forever begin
            @(negedge clk);
            if (mon_on && irq) begin
                addr = 3'd1; rd = 1'b1;
                #1 v = rdata;
                @(negedge clk);
                rd = 1'b0;
                if (expq.size() == 0) begin
                    chk("R4 unexpected byte", int'(v), -1);
                end else begin
                    chk("R4 scoreboard byte", int'(v), int'(expq.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        #1 chk("R1 irq idle", int'(irq), 1);
        reg_rd(3'd2, v); chk("R1 status", int'(v), 'h0C);
        reg_rd(3'd3, v); chk("R1 enable", int'(v), 0);
        reg_rd(3'd4, v); chk("R1 divisor", int'(v), 0);
        reg_rd(3'd5, v); chk("R1 offset 5", int'(v), 0);
        reg_rd(3'd7, v); chk("R1 offset 7", int'(v), 0);

        // R9 live bus level
        reg_rd(3'd0, v); chk("R9 bus level high", int'(v), 'h08);

        // R2 reset low length, R3 presence with a device
        slv_pres = 1'b1;
        reg_wr(3'd0, 8'h01);
        n = 0;
        while (dq_oe) begin n++; @(negedge clk); end
        chk("R2 reset low ticks", n, 480);
        repeat (600) @(negedge clk);
        reg_rd(3'd2, v); chk("R3 device answered", int'(v), 'h0D);
        reg_rd(3'd2, v); chk("R7 pd cleared by read", int'(v), 'h0C);

        // R2 busy bit, R9 line low, R3 no device
        slv_pres = 1'b0;
        reg_wr(3'd0, 8'h01);
        reg_rd(3'd0, v); chk("R2 busy bit", int'(v), 'h01);
        repeat (1000) @(negedge clk);
        reg_rd(3'd2, v); chk("R3 no device", int'(v), 'h0F);

        // R4 LSB first slot widths
        slv_byte = 8'hFF;
        reg_wr(3'd1, 8'h01);
        low_len(n); chk("R4 first slot is bit0=1", n, 6);
        low_len(n); chk("R4 second slot is bit1=0", n, 60);
        repeat (600) @(negedge clk);
        reg_rd(3'd1, v); chk("R4 echo byte", int'(v), 'h01);

        // R6 polarity, R7 hold
        reg_wr(3'd3, 8'h08);
        #1 chk("R6 active low", int'(irq), 0);
        reg_wr(3'd3, 8'h0A);
        #1 chk("R6 active high", int'(irq), 1);
        reg_rd(3'd2, v); chk("R8 rsrf kept after data read", int'(v), 'h2E);
        #1 chk("R7 irq released by status read", int'(irq), 0);
        reg_wr(3'd3, 8'h00);
        #1 chk("R6 nothing enabled", int'(irq), 1);

        // R5 and R7 in the same cycle as completion
        slv_byte = 8'hA5;
        reg_wr(3'd1, 8'hFF);
        repeat (559) @(negedge clk);
        addr = 3'd2; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
        chk("R5 flags low during byte", int'(v & 8'h3C), 0);
        reg_rd(3'd2, v); chk("R7 completion wins over clear", int'(v & 8'h3D), 'h3C);
        reg_rd(3'd1, v); chk("R4 pure read", int'(v), 'hA5);

        // R8 data read clears only rbf
        slv_byte = 8'hFF;
        reg_wr(3'd1, 8'h3C);
        repeat (600) @(negedge clk);
        reg_rd(3'd1, v); chk("R4 transmit echo", int'(v), 'h3C);
        reg_rd(3'd2, v); chk("R8 rbf cleared rsrf kept", int'(v & 8'h3D), 'h2C);

        // R11 write while busy ignored
        reg_wr(3'd1, 8'h00);
        repeat (100) @(negedge clk);
        reg_wr(3'd1, 8'hFF);
        reg_wr(3'd0, 8'h01);
        repeat (500) @(negedge clk);
        reg_rd(3'd1, v); chk("R11 first byte kept", int'(v), 'h00);
        n = 0;
        repeat (100) begin @(negedge clk); if (dq_oe) n++; end
        chk("R11 no extra slots", n, 0);

        // R10 soft reset mid byte
        reg_wr(3'd3, 8'h12);
        reg_wr(3'd1, 8'h00);
        repeat (100) @(negedge clk);
        reg_wr(3'd0, 8'h20);
        #1 chk("R10 bus released", int'(dq_oe), 0);
        reg_rd(3'd2, v); chk("R10 status restored", int'(v), 'h0C);
        reg_rd(3'd3, v); chk("R10 enable kept", int'(v), 'h12);
        repeat (100) @(negedge clk);

        // R4 scoreboard run
        slv_pres = 1'b1;
        bus_reset();
        mon_on = 1'b1;
        sb_byte(8'hFF, 8'hA5);
        sb_byte(8'h96, 8'h0F);
        sb_byte(8'hFF, 8'h5A);
        sb_byte(8'h3C, 8'hFF);
        mon_on = 1'b0;
        chk("R4 scoreboard drained", expq.size(), 0);
        reg_wr(3'd3, 8'h00);

        // R12 divisor
        slv_pres = 1'b0;
        reg_wr(3'd4, 8'h03);
        reg_rd(3'd4, v); chk("R12 divisor readback", int'(v), 3);
        reg_wr(3'd0, 8'h01);
        n = 0;
        while (dq_oe) begin n++; @(negedge clk); end
        chk("R12 reset low clocks", n, 1920);
        repeat (2500) @(negedge clk);
        reg_rd(3'd0, v); chk("R12 sequence finished", int'(v), 'h08);
        reg_wr(3'd4, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule